// File: doc/BRIEF.md
# Pipelined DES Round Datapath

This block performs the DES cipher transform on one 64-bit block per clock. A block enters with a valid flag and goes through the initial permutation. It then moves through sixteen registered Feistel round stages and leaves through the final permutation. Each round has its own 48-bit subkey lane on a single wide subkey bus. The block holds no key state of its own, so a different key can go with every block.

The caller runs the key schedule and skews its output. The subkey for round k (k counted from 0) must be on its lane exactly k cycles after the block is presented at the input. Decryption uses the same datapath: the caller supplies the sixteen subkeys in reverse order. A valid flag travels alongside each block. Cycles with no valid input become bubbles that reach the output in the same relative positions.

Top module: `des_pipe`

## Requirements
- R1: A synchronous active-high `rst` clears every stage's valid flag. `out_valid` is low in the cycle after any cycle in which `rst` is sampled high, and blocks that were in flight at that moment never appear at the output.
- R2: Bit 63 of `in_block` and `out_block` is DES bit 1 (the most significant). After the initial permutation, bits 63..32 form the left half and bits 31..0 form the right half.
- R3: Each round expands the right half from 32 to 48 bits and XORs the result with its subkey. It splits the 48 bits into eight 6-bit groups, most significant first, and each group goes to the S-box of the same position. An S-box row is formed from the group's outer two bits and its column from the inner four bits. The 32-bit S-box result goes through the P permutation and is XORed into the left half. Key 133457799BBCDFF1 with plaintext 0123456789ABCDEF gives 85E813540F0AB405.
- R4: Round k (k = 0..15) reads its subkey from `subkeys[48*k+47 : 48*k]`, in the cycle that falls k cycles after the block was presented. Lanes belonging to other blocks in that cycle have no effect on it.
- R5: The old right half becomes the new left half of every round. After round 16 the output is formed by applying the final permutation to {R16, L16}, that is, right half first.
- R6: A block presented with `in_valid` high while `rst` is low appears with `out_valid` high exactly 16 cycles later.
- R7: Blocks may be presented on consecutive cycles, each with a different key. Each one leaves the block on consecutive cycles with its own correct result.
- R8: A cycle with `in_valid` low produces `out_valid` low 16 cycles later. An empty pipeline with no input stays empty.
- R9: Supplying the subkeys in reverse round order decrypts: ciphertext 85E813540F0AB405 gives 0123456789ABCDEF under the reversed schedule of the key in R3.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset of the valid flags |
| in_valid | input | 1 | Marks `in_block` as a block to process |
| in_block | input | 64 | Input block, bit 63 is DES bit 1 |
| subkeys | input | 768 | Sixteen 48-bit round subkey lanes, round k in bits 48k+47..48k |
| out_valid | output | 1 | Marks `out_block` as a finished block |
| out_block | output | 64 | Output block, bit 63 is DES bit 1 |

## Verification
The assertions assume the subkey lanes are already skewed, so a block's round k key is present k cycles after it enters. They also assume `rst` is synchronous and held for at least one rising edge. The bench keeps to these assumptions with one cycle-indexed driver. For every cycle c and round k, that driver places on lane k the subkey of the block presented in cycle c−k. Lanes with no live block get a distinct filler pattern, so a wrongly aligned lane corrupts the result where the bench can see it. Reset is only raised or dropped on a falling clock edge.

// File: rtl/des_pipe_pkg.sv
package des_pipe_pkg;

    localparam int BLOCK_W   = 64;
    localparam int HALF_W    = 32;
    localparam int SUBKEY_W  = 48;
    localparam int NUM_BOXES = 8;
    localparam int BOX_IN_W  = 6;
    localparam int BOX_OUT_W = 4;

    // Source bit numbers, 1 = most significant, for each output bit in order.
    localparam byte unsigned INIT_PERM [64] = '{
        58, 50, 42, 34, 26, 18, 10,  2, 60, 52, 44, 36, 28, 20, 12,  4,
        62, 54, 46, 38, 30, 22, 14,  6, 64, 56, 48, 40, 32, 24, 16,  8,
        57, 49, 41, 33, 25, 17,  9,  1, 59, 51, 43, 35, 27, 19, 11,  3,
        61, 53, 45, 37, 29, 21, 13,  5, 63, 55, 47, 39, 31, 23, 15,  7
    };

    localparam byte unsigned LAST_PERM [64] = '{
        40,  8, 48, 16, 56, 24, 64, 32, 39,  7, 47, 15, 55, 23, 63, 31,
        38,  6, 46, 14, 54, 22, 62, 30, 37,  5, 45, 13, 53, 21, 61, 29,
        36,  4, 44, 12, 52, 20, 60, 28, 35,  3, 43, 11, 51, 19, 59, 27,
        34,  2, 42, 10, 50, 18, 58, 26, 33,  1, 41,  9, 49, 17, 57, 25
    };

    localparam byte unsigned WIDEN_MAP [48] = '{
        32,  1,  2,  3,  4,  5,  4,  5,  6,  7,  8,  9,
         8,  9, 10, 11, 12, 13, 12, 13, 14, 15, 16, 17,
        16, 17, 18, 19, 20, 21, 20, 21, 22, 23, 24, 25,
        24, 25, 26, 27, 28, 29, 28, 29, 30, 31, 32,  1
    };

    localparam byte unsigned MIX_PERM [32] = '{
        16,  7, 20, 21, 29, 12, 28, 17,  1, 15, 23, 26,  5, 18, 31, 10,
         2,  8, 24, 14, 32, 27,  3,  9, 19, 13, 30,  6, 22, 11,  4, 25
    };

    // Substitution tables, indexed row*16 + column.
    localparam byte unsigned SUB0 [64] = '{
        14,  4, 13,  1,  2, 15, 11,  8,  3, 10,  6, 12,  5,  9,  0,  7,
         0, 15,  7,  4, 14,  2, 13,  1, 10,  6, 12, 11,  9,  5,  3,  8,
         4,  1, 14,  8, 13,  6,  2, 11, 15, 12,  9,  7,  3, 10,  5,  0,
        15, 12,  8,  2,  4,  9,  1,  7,  5, 11,  3, 14, 10,  0,  6, 13
    };
    localparam byte unsigned SUB1 [64] = '{
        15,  1,  8, 14,  6, 11,  3,  4,  9,  7,  2, 13, 12,  0,  5, 10,
         3, 13,  4,  7, 15,  2,  8, 14, 12,  0,  1, 10,  6,  9, 11,  5,
         0, 14,  7, 11, 10,  4, 13,  1,  5,  8, 12,  6,  9,  3,  2, 15,
        13,  8, 10,  1,  3, 15,  4,  2, 11,  6,  7, 12,  0,  5, 14,  9
    };
    localparam byte unsigned SUB2 [64] = '{
        10,  0,  9, 14,  6,  3, 15,  5,  1, 13, 12,  7, 11,  4,  2,  8,
        13,  7,  0,  9,  3,  4,  6, 10,  2,  8,  5, 14, 12, 11, 15,  1,
        13,  6,  4,  9,  8, 15,  3,  0, 11,  1,  2, 12,  5, 10, 14,  7,
         1, 10, 13,  0,  6,  9,  8,  7,  4, 15, 14,  3, 11,  5,  2, 12
    };
    localparam byte unsigned SUB3 [64] = '{
         7, 13, 14,  3,  0,  6,  9, 10,  1,  2,  8,  5, 11, 12,  4, 15,
        13,  8, 11,  5,  6, 15,  0,  3,  4,  7,  2, 12,  1, 10, 14,  9,
        10,  6,  9,  0, 12, 11,  7, 13, 15,  1,  3, 14,  5,  2,  8,  4,
         3, 15,  0,  6, 10,  1, 13,  8,  9,  4,  5, 11, 12,  7,  2, 14
    };
    localparam byte unsigned SUB4 [64] = '{
         2, 12,  4,  1,  7, 10, 11,  6,  8,  5,  3, 15, 13,  0, 14,  9,
        14, 11,  2, 12,  4,  7, 13,  1,  5,  0, 15, 10,  3,  9,  8,  6,
         4,  2,  1, 11, 10, 13,  7,  8, 15,  9, 12,  5,  6,  3,  0, 14,
        11,  8, 12,  7,  1, 14,  2, 13,  6, 15,  0,  9, 10,  4,  5,  3
    };
    localparam byte unsigned SUB5 [64] = '{
        12,  1, 10, 15,  9,  2,  6,  8,  0, 13,  3,  4, 14,  7,  5, 11,
        10, 15,  4,  2,  7, 12,  9,  5,  6,  1, 13, 14,  0, 11,  3,  8,
         9, 14, 15,  5,  2,  8, 12,  3,  7,  0,  4, 10,  1, 13, 11,  6,
         4,  3,  2, 12,  9,  5, 15, 10, 11, 14,  1,  7,  6,  0,  8, 13
    };
    localparam byte unsigned SUB6 [64] = '{
         4, 11,  2, 14, 15,  0,  8, 13,  3, 12,  9,  7,  5, 10,  6,  1,
        13,  0, 11,  7,  4,  9,  1, 10, 14,  3,  5, 12,  2, 15,  8,  6,
         1,  4, 11, 13, 12,  3,  7, 14, 10, 15,  6,  8,  0,  5,  9,  2,
         6, 11, 13,  8,  1,  4, 10,  7,  9,  5,  0, 15, 14,  2,  3, 12
    };
    localparam byte unsigned SUB7 [64] = '{
        13,  2,  8,  4,  6, 15, 11,  1, 10,  9,  3, 14,  5,  0, 12,  7,
         1, 15, 13,  8, 10,  3,  7,  4, 12,  5,  6, 11,  0, 14,  9,  2,
         7, 11,  4,  1,  9, 12, 14,  2,  0,  6, 10, 13, 15,  3,  5,  8,
         2,  1, 14,  7,  4, 10,  8, 13, 15, 12,  9,  0,  3,  5,  6, 11
    };

    function automatic logic [BLOCK_W-1:0] apply_init_perm(input logic [BLOCK_W-1:0] d);
        logic [BLOCK_W-1:0] r;
        for (int i = 0; i < BLOCK_W; i++)
            r[BLOCK_W-1-i] = d[BLOCK_W - int'(INIT_PERM[i])];
        return r;
    endfunction

    function automatic logic [BLOCK_W-1:0] apply_last_perm(input logic [BLOCK_W-1:0] d);
        logic [BLOCK_W-1:0] r;
        for (int i = 0; i < BLOCK_W; i++)
            r[BLOCK_W-1-i] = d[BLOCK_W - int'(LAST_PERM[i])];
        return r;
    endfunction

    function automatic logic [SUBKEY_W-1:0] widen_half(input logic [HALF_W-1:0] d);
        logic [SUBKEY_W-1:0] r;
        for (int i = 0; i < SUBKEY_W; i++)
            r[SUBKEY_W-1-i] = d[HALF_W - int'(WIDEN_MAP[i])];
        return r;
    endfunction

    function automatic logic [HALF_W-1:0] mix_half(input logic [HALF_W-1:0] d);
        logic [HALF_W-1:0] r;
        for (int i = 0; i < HALF_W; i++)
            r[HALF_W-1-i] = d[HALF_W - int'(MIX_PERM[i])];
        return r;
    endfunction

    function automatic logic [BOX_OUT_W-1:0] box_lookup(input int box,
                                                        input logic [BOX_IN_W-1:0] x);
        int          idx;
        byte unsigned v;
        idx = {x[5], x[0]} * 16 + int'(x[4:1]);
        unique case (box)
            0:       v = SUB0[idx];
            1:       v = SUB1[idx];
            2:       v = SUB2[idx];
            3:       v = SUB3[idx];
            4:       v = SUB4[idx];
            5:       v = SUB5[idx];
            6:       v = SUB6[idx];
            default: v = SUB7[idx];
        endcase
        return v[BOX_OUT_W-1:0];
    endfunction

endpackage

// File: rtl/des_feistel_f.sv
module des_feistel_f
    import des_pipe_pkg::*;
(
    input  logic [HALF_W-1:0]   half_in,
    input  logic [SUBKEY_W-1:0] round_key,
    output logic [HALF_W-1:0]   f_out
);

    logic [SUBKEY_W-1:0] keyed;
    logic [HALF_W-1:0]   subst;

    assign keyed = widen_half(half_in) ^ round_key;

    for (genvar b = 0; b < NUM_BOXES; b++) begin : g_box
        assign subst[HALF_W-1-BOX_OUT_W*b -: BOX_OUT_W] =
            box_lookup(b, keyed[SUBKEY_W-1-BOX_IN_W*b -: BOX_IN_W]);
    end

    assign f_out = mix_half(subst);

endmodule

// File: rtl/des_round_stage.sv
module des_round_stage
    import des_pipe_pkg::*;
(
    input  logic                clk,
    input  logic                rst,
    input  logic                valid_in,
    input  logic [HALF_W-1:0]   left_in,
    input  logic [HALF_W-1:0]   right_in,
    input  logic [SUBKEY_W-1:0] round_key,
    output logic                valid_out,
    output logic [HALF_W-1:0]   left_out,
    output logic [HALF_W-1:0]   right_out
);

    logic [HALF_W-1:0] f_val;

    des_feistel_f f_i (
        .half_in  (right_in),
        .round_key(round_key),
        .f_out    (f_val)
    );

    always_ff @(posedge clk) begin
        if (rst) valid_out <= 1'b0;
        else     valid_out <= valid_in;
    end

    // Data lanes carry no reset; the valid flag qualifies them.
    always_ff @(posedge clk) begin
        left_out  <= right_in;
        right_out <= left_in ^ f_val;
    end

    // R8: a stage never reports a block it was not handed
    a_r8_no_phantom_valid: assert property (@(posedge clk) disable iff (rst)
        valid_out |-> $past(valid_in));

    // R5: the previous right half becomes the next left half
    a_r5_left_from_right: assert property (@(posedge clk) disable iff (rst)
        valid_in |=> (left_out == $past(right_in)));

endmodule

// File: rtl/des_pipe.sv
module des_pipe
    import des_pipe_pkg::*;
#(
    parameter int NUM_ROUNDS = 16
) (
    input  logic                           clk,
    input  logic                           rst,
    input  logic                           in_valid,
    input  logic [BLOCK_W-1:0]             in_block,
    input  logic [NUM_ROUNDS*SUBKEY_W-1:0] subkeys,
    output logic                           out_valid,
    output logic [BLOCK_W-1:0]             out_block
);

    logic [NUM_ROUNDS:0] valid_s;
    logic [HALF_W-1:0]   left_s  [NUM_ROUNDS+1];
    logic [HALF_W-1:0]   right_s [NUM_ROUNDS+1];
    logic [BLOCK_W-1:0]  permuted_in;

    assign permuted_in = apply_init_perm(in_block);
    assign valid_s[0]  = in_valid;
    assign left_s[0]   = permuted_in[BLOCK_W-1:HALF_W];
    assign right_s[0]  = permuted_in[HALF_W-1:0];

    for (genvar g = 0; g < NUM_ROUNDS; g++) begin : g_round
        des_round_stage stage_i (
            .clk      (clk),
            .rst      (rst),
            .valid_in (valid_s[g]),
            .left_in  (left_s[g]),
            .right_in (right_s[g]),
            .round_key(subkeys[g*SUBKEY_W +: SUBKEY_W]),
            .valid_out(valid_s[g+1]),
            .left_out (left_s[g+1]),
            .right_out(right_s[g+1])
        );
    end

    // Right half first undoes the swap of the last round.
    assign out_block = apply_last_perm({right_s[NUM_ROUNDS], left_s[NUM_ROUNDS]});
    assign out_valid = valid_s[NUM_ROUNDS];

    // R1: reset empties the pipeline at once
    a_r1_reset_idle: assert property (@(posedge clk)
        $past(rst) |-> !out_valid);

    // R8: an empty pipeline with no input stays empty
    a_r8_empty_stays_empty: assert property (@(posedge clk) disable iff (rst)
        (!in_valid && ($countones(valid_s[NUM_ROUNDS:1]) == 0))
            |=> ($countones(valid_s[NUM_ROUNDS:1]) == 0));

endmodule

// File: tb/des_pipe_tb_top.sv
`timescale 1ns/1ps
module des_pipe_tb_top;

    localparam int ROUNDS = 16;
    localparam int SKW    = 48;
    localparam int LAT    = 16;
    localparam int MAXN   = 32;

    logic                   clk = 1'b0;
    logic                   rst = 1'b1;
    logic                   in_valid = 1'b0;
    logic [63:0]            in_block = '0;
    logic [ROUNDS*SKW-1:0]  subkeys = '0;
    logic                   out_valid;
    logic [63:0]            out_block;

    int checks   = 0;
    int failures = 0;
    bit done     = 1'b0;

    logic [63:0]  pt_tab  [6];
    logic [63:0]  exp_tab [6];
    int           set_tab [6];
    logic [47:0]  sk_tab  [4][ROUNDS];

    bit s_valid [MAXN];
    int s_id    [MAXN];

    des_pipe dut_i (
        .clk      (clk),
        .rst      (rst),
        .in_valid (in_valid),
        .in_block (in_block),
        .subkeys  (subkeys),
        .out_valid(out_valid),
        .out_block(out_block)
    );

    always #4 clk = ~clk;

    task automatic report(input string tag, input bit ok,
                          input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // Drive cycle c of an n-slot stream with skewed subkey lanes.
    task automatic drive_slot(input int c, input int n);
        in_valid = (c < n) ? s_valid[c] : 1'b0;
        in_block = (c < n) ? pt_tab[s_id[c]] : 64'h0;
        for (int k = 0; k < ROUNDS; k++) begin
            int idx = c - k;
            if (idx >= 0 && idx < n && s_valid[idx])
                subkeys[k*SKW +: SKW] = sk_tab[set_tab[s_id[idx]]][k];
            else
                subkeys[k*SKW +: SKW] = 48'h5A3C_96E1_0F77 ^ 48'(k * 48'h1111_1111);
        end
    endtask

    task automatic run_stream(input int n, input string tag);
        for (int c = 0; c < n + LAT + 4; c++) begin
            int j;
            bit ev;
            @(negedge clk);
            j  = c - LAT;
            ev = (j >= 0 && j < n) ? s_valid[j] : 1'b0;
            report({tag, " out_valid"}, out_valid === ev, 64'(out_valid), 64'(ev));
            if (ev)
                report({tag, " data"}, out_block === exp_tab[s_id[j]],
                       out_block, exp_tab[s_id[j]]);
            drive_slot(c, n);
        end
    endtask

    task automatic t_reset_state;
        for (int c = 0; c < 3; c++) begin
            @(negedge clk);
            report("R1 reset state", out_valid === 1'b0, 64'(out_valid), 64'h0);
        end
        rst = 1'b0;
    endtask

    task automatic t_known_answer;
        s_valid[0] = 1; s_id[0] = 0;
        run_stream(1, "R3 R2 R5 known answer");
    endtask

    task automatic t_decrypt;
        s_valid[0] = 1; s_id[0] = 1;
        run_stream(1, "R9 reversed subkeys");
    endtask

    task automatic t_uniform_keys;
        s_valid[0] = 1; s_id[0] = 2;
        s_valid[1] = 0; s_id[1] = 0;
        s_valid[2] = 1; s_id[2] = 4;
        s_valid[3] = 1; s_id[3] = 3;
        run_stream(4, "R3 uniform keys");
    endtask

    task automatic t_back_to_back;
        int order [8] = '{0, 1, 2, 3, 4, 5, 0, 4};
        for (int i = 0; i < 8; i++) begin
            s_valid[i] = 1; s_id[i] = order[i];
        end
        run_stream(8, "R7 R4 back-to-back keys");
    endtask

    task automatic t_bubbles;
        bit pat [7] = '{1, 0, 0, 1, 1, 0, 1};
        for (int i = 0; i < 7; i++) begin
            s_valid[i] = pat[i]; s_id[i] = (i * 5) % 6;
        end
        run_stream(7, "R8 R6 bubbles and latency");
    endtask

    task automatic t_reset_flush;
        for (int i = 0; i < 6; i++) begin
            s_valid[i] = 1; s_id[i] = i;
        end
        for (int c = 0; c < 6; c++) begin
            @(negedge clk);
            drive_slot(c, 6);
        end
        @(negedge clk);
        rst = 1'b1; in_valid = 1'b0;
        @(negedge clk);
        rst = 1'b0;
        for (int c = 0; c < LAT + 4; c++) begin
            @(negedge clk);
            report("R1 flushed by reset", out_valid === 1'b0, 64'(out_valid), 64'h0);
        end
    endtask

    initial begin
        logic [47:0] base [ROUNDS] = '{
            48'h1B02EFFC7072, 48'h79AED9DBC9E5, 48'h55FC8A42CF99, 48'h72ADD6DB351D,
            48'h7CEC07EB53A8, 48'h63A53E507B2F, 48'hEC84B7F618BC, 48'hF78A3AC13BFB,
            48'hE0DBEBEDE781, 48'hB1F347BA464F, 48'h215FD3DED386, 48'h7571F59467E9,
            48'h97C5D1FABA41, 48'h5F43B7F2E73A, 48'hBF918D3D3F0A, 48'hCB3D8B0E17F5
        };
        for (int k = 0; k < ROUNDS; k++) begin
            sk_tab[0][k] = base[k];
            sk_tab[1][k] = base[ROUNDS-1-k];
            sk_tab[2][k] = 48'h0;
            sk_tab[3][k] = 48'hFFFF_FFFF_FFFF;
        end
        pt_tab[0] = 64'h0123456789ABCDEF; set_tab[0] = 0; exp_tab[0] = 64'h85E813540F0AB405;
        pt_tab[1] = 64'h85E813540F0AB405; set_tab[1] = 1; exp_tab[1] = 64'h0123456789ABCDEF;
        pt_tab[2] = 64'h0000000000000000; set_tab[2] = 2; exp_tab[2] = 64'h8CA64DE9C1B123A7;
        pt_tab[3] = 64'h95F8A5E5DD31D900; set_tab[3] = 2; exp_tab[3] = 64'h8000000000000000;
        pt_tab[4] = 64'hFFFFFFFFFFFFFFFF; set_tab[4] = 3; exp_tab[4] = 64'h7359B2163E4EDC58;
        pt_tab[5] = 64'h8CA64DE9C1B123A7; set_tab[5] = 2; exp_tab[5] = 64'h0000000000000000;

        t_reset_state();
        t_known_answer();
        t_decrypt();
        t_uniform_keys();
        t_back_to_back();
        t_bubbles();
        t_reset_flush();

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++;
            failures++;
            $display("FAIL R6 watchdog expired actual=running expected=finished");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

endmodule